// File: doc/BRIEF.md
# Conditional Access Tag Tracker

This block sits beside a private L1 data cache that two hardware threads share. It lets a thread make loads and stores conditional on a set of cache lines it has chosen to watch. A watched line must not have been invalidated, evicted or written by the sibling thread since the thread began watching it. The block keeps a small set-associative directory of resident lines. Each directory entry carries one watch bit per thread, and each thread also has one sticky "revoked" flag.

The block accepts four operations, one at a time:
- **Conditional read** watches the line and passes unless the thread is revoked.
- **Conditional write** passes only if the thread is not revoked and already watches the line.
- **Drop one** stops watching a single line.
- **Drop all** clears every watch bit of the thread and its revoked flag.

Each operation returns a pass/fail status and a go signal for the load/store data path.

Coherence invalidations, line fills (with the evictions they cause), plain stores and per-thread context switches arrive as event inputs. These events set the revoked flags of the threads that watch the affected lines. Comparing data values plays no part in the check; only these events decide the outcome.

Top module: `ca_tag_tracker`

## Requirements
- R1: A conditional read (op code 0) that hits a resident line while its thread is not revoked sets the thread's watch bit for that line. It reports op_done with op_pass=1 and op_go=1 on the cycle after acceptance.
- R2: A conditional read issued while its thread is revoked reports op_pass=0 and op_go=0 on the cycle after acceptance, and requests no fill.
- R3: A conditional write (op code 1) passes, with op_go=1, only when the thread is not revoked and watches the addressed line. Otherwise it fails with op_go=0. A conditional write never sets a watch bit.
- R4: Drop-one (op code 2) clears the thread's watch bit for the addressed line and reports op_pass=1, op_go=0. A later invalidation of that line leaves the thread not revoked. On a line the thread does not watch, drop-one changes nothing.
- R5: Drop-all (op code 3) clears all watch bits of the thread and its revoked flag, and reports op_pass=1, op_go=0.
- R6: An invalidation (inv_valid) is acknowledged on inv_ack the next cycle. At that same clock edge, the revoked flag of every thread watching the line is set and the line leaves the directory.
- R7: A fill into a set with no free way evicts a way chosen by a per-set round-robin pointer. The pointer starts at way 0 and advances after each such eviction. A free way, lowest index first, is always used before any eviction. The threads watching the evicted line are revoked at the same edge that installs the new line.
- R8: Watch bits and revoked flags are kept separately per thread. An event on a line watched only by one thread does not revoke the other thread.
- R9: A pulse on ctx_switch[t] sets thread t's revoked flag.
- R10: A line spans 64 bytes. Address bits [5:0] play no part in any lookup, so watching one byte watches the whole line.
- R11: A store by one thread to a line watched by the other thread revokes the other thread. The store can be a plain store on st_* or a passing conditional write. A thread's own stores do not revoke it.
- R12: When an event that revokes a thread arrives in the same cycle as a conditional read or write from that thread, the event wins and the operation fails.
- R13: A conditional read that misses holds op_ready low and raises fill_req with the line-aligned address. It reports its status on the cycle after the matching fill_valid, at which point the line is installed and watched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when op_ready is high |
| op_code | input | 2 | 0 cond. read, 1 cond. write, 2 drop one, 3 drop all |
| op_thread | input | 1 | Issuing hardware thread |
| op_addr | input | ADDR_W | Byte address of the operation |
| op_ready | output | 1 | Low while a missing conditional read waits for its fill |
| op_done | output | 1 | One-cycle status strobe |
| op_pass | output | 1 | Operation succeeded |
| op_go | output | 1 | Let the data path perform the load or store |
| rsp_thread | output | 1 | Thread the status belongs to |
| fill_req | output | 1 | Fill requested for a missing conditional read |
| fill_req_addr | output | ADDR_W | Line-aligned address of the requested fill |
| fill_valid | input | 1 | A line is being installed |
| fill_addr | input | ADDR_W | Address of the installed line |
| inv_valid | input | 1 | Coherence invalidation request |
| inv_addr | input | ADDR_W | Address being invalidated |
| inv_ack | output | 1 | Invalidation acknowledgement |
| st_valid | input | 1 | Plain store performed by a thread |
| st_thread | input | 1 | Thread performing the plain store |
| st_addr | input | ADDR_W | Plain store address |
| ctx_switch | input | 2 | Per-thread context-switch pulse |

## Verification
Two things can land in the same clock cycle: a revoking event and a conditional operation from the thread that event revokes. The bench provokes this in two ways. First, it drives inv_valid on a watched line together with a conditional write to that line. Second, it pulses ctx_switch together with a conditional read. In both cases it expects a failed status with op_go low, and an acknowledgement for the invalidation. A sweep over both threads, every set and several byte offsets checks hits, misses and write permissions. Directed sequences then cover eviction order, the sibling's stores and the drop operations.

// File: rtl/ca_tag_tracker.sv
module ca_tag_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WAYS       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              op_thread,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_ready,
  output logic              op_done,
  output logic              op_pass,
  output logic              op_go,
  output logic              rsp_thread,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ack,
  input  logic              st_valid,
  input  logic              st_thread,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        ctx_switch
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [1:0] OP_CRD = 2'd0, OP_CWR = 2'd1, OP_UN1 = 2'd2, OP_UNA = 2'd3;

  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [1:0]        mon_q [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q  [SETS];
  logic [1:0]        rev_q;
  logic              busy_q, pthr_q, done_q, pass_q, go_q, rthr_q, ack_q;
  logic [LINE_W-1:0] pline_q;

  logic [SET_W-1:0] o_set, i_set, s_set, f_set;
  logic [TAG_W-1:0] o_tag, i_tag, s_tag, f_tag;
  assign o_set = op_addr[OFF_W +: SET_W];
  assign i_set = inv_addr[OFF_W +: SET_W];
  assign s_set = st_addr[OFF_W +: SET_W];
  assign f_set = fill_addr[OFF_W +: SET_W];
  assign o_tag = op_addr[ADDR_W-1 -: TAG_W];
  assign i_tag = inv_addr[ADDR_W-1 -: TAG_W];
  assign s_tag = st_addr[ADDR_W-1 -: TAG_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic unused_low_bits;
  assign unused_low_bits = ^{op_addr[OFF_W-1:0], inv_addr[OFF_W-1:0],
                             st_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic o_hit, i_hit, s_hit, f_hit, f_free;
  logic [WAY_W-1:0] o_way, i_way, s_way, f_way, f_vic;
  always_comb begin
    o_hit = 1'b0; i_hit = 1'b0; s_hit = 1'b0; f_hit = 1'b0; f_free = 1'b0;
    o_way = '0; i_way = '0; s_way = '0; f_way = '0; f_vic = rr_q[f_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[o_set][w] && tag_q[o_set][w] == o_tag) begin o_hit = 1'b1; o_way = WAY_W'(w); end
      if (vld_q[i_set][w] && tag_q[i_set][w] == i_tag) begin i_hit = 1'b1; i_way = WAY_W'(w); end
      if (vld_q[s_set][w] && tag_q[s_set][w] == s_tag) begin s_hit = 1'b1; s_way = WAY_W'(w); end
      if (vld_q[f_set][w] && tag_q[f_set][w] == f_tag) begin f_hit = 1'b1; f_way = WAY_W'(w); end
      if (!vld_q[f_set][w]) begin f_free = 1'b1; f_vic = WAY_W'(w); end
    end
  end

  logic             f_install, f_evict, pend_match, acc, o_kill, o_live, o_mon, o_rev, cw_ok;
  logic [WAY_W-1:0] f_tgt;
  logic [1:0]       i_rev, s_rev, e_rev, cw_rev, rev_set, rev_nx;

  assign f_install  = fill_valid && !f_hit;
  assign f_evict    = f_install && !f_free;
  assign f_tgt      = f_hit ? f_way : f_vic;
  assign pend_match = busy_q && fill_valid && fill_addr[ADDR_W-1:OFF_W] == pline_q;
  assign acc        = op_valid && !busy_q;

  assign i_rev = (inv_valid && i_hit) ? mon_q[i_set][i_way] : 2'b00;
  assign s_rev = (st_valid && s_hit) ? (mon_q[s_set][s_way] & (st_thread ? 2'b01 : 2'b10)) : 2'b00;
  assign e_rev = f_evict ? mon_q[f_set][f_vic] : 2'b00;

  assign o_kill = (inv_valid && i_hit && i_set == o_set && i_way == o_way) ||
                  (f_evict && f_set == o_set && f_vic == o_way);
  assign o_live = o_hit && !o_kill;
  assign o_mon  = o_live && mon_q[o_set][o_way][op_thread];
  assign o_rev  = rev_q[op_thread] | i_rev[op_thread] | s_rev[op_thread] |
                  e_rev[op_thread] | ctx_switch[op_thread];
  assign cw_ok  = acc && op_code == OP_CWR && !o_rev && o_mon;
  assign cw_rev = cw_ok ? (mon_q[o_set][o_way] & (op_thread ? 2'b01 : 2'b10)) : 2'b00;
  assign rev_set = rev_q | i_rev | s_rev | e_rev | ctx_switch | cw_rev;

  always_comb begin
    rev_nx = rev_set;
    if (acc && op_code == OP_UNA) rev_nx[op_thread] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          mon_q[s][w] <= 2'b00;
        end
      end
      rev_q   <= 2'b00;
      busy_q  <= 1'b0;
      pthr_q  <= 1'b0;
      pline_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      go_q    <= 1'b0;
      rthr_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      rev_q  <= rev_nx;
      ack_q  <= inv_valid;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      go_q   <= 1'b0;
      if (inv_valid && i_hit) begin
        vld_q[i_set][i_way] <= 1'b0;
        mon_q[i_set][i_way] <= 2'b00;
      end
      if (f_install) begin
        vld_q[f_set][f_vic] <= 1'b1;
        tag_q[f_set][f_vic] <= f_tag;
        mon_q[f_set][f_vic] <= 2'b00;
        if (!f_free)
          rr_q[f_set] <= (rr_q[f_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[f_set] + 1'b1;
      end
      if (pend_match) begin
        mon_q[f_set][f_tgt][pthr_q] <= 1'b1;
        busy_q <= 1'b0;
        done_q <= 1'b1;
        pass_q <= !rev_set[pthr_q];
        go_q   <= !rev_set[pthr_q];
        rthr_q <= pthr_q;
      end
      if (acc) begin
        rthr_q <= op_thread;
        case (op_code)
          OP_CRD: begin
            if (o_rev) begin
              done_q <= 1'b1;
            end else if (o_live) begin
              mon_q[o_set][o_way][op_thread] <= 1'b1;
              done_q <= 1'b1;
              pass_q <= 1'b1;
              go_q   <= 1'b1;
            end else begin
              busy_q  <= 1'b1;
              pthr_q  <= op_thread;
              pline_q <= op_addr[ADDR_W-1:OFF_W];
            end
          end
          OP_CWR: begin
            done_q <= 1'b1;
            pass_q <= cw_ok;
            go_q   <= cw_ok;
          end
          OP_UN1: begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
            if (o_live) mon_q[o_set][o_way][op_thread] <= 1'b0;
          end
          default: begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
            for (int s = 0; s < SETS; s++)
              for (int w = 0; w < WAYS; w++)
                mon_q[s][w][op_thread] <= 1'b0;
          end
        endcase
      end
    end
  end

  assign op_ready      = !busy_q;
  assign op_done       = done_q;
  assign op_pass       = pass_q;
  assign op_go         = go_q;
  assign rsp_thread    = rthr_q;
  assign fill_req      = busy_q;
  assign fill_req_addr = {pline_q, {OFF_W{1'b0}}};
  assign inv_ack       = ack_q;
endmodule

// File: rtl/ca_tag_tracker_chk.sv
module ca_tag_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_code,
  input logic       op_thread,
  input logic       op_ready,
  input logic       op_done,
  input logic       op_pass,
  input logic       op_go,
  input logic       fill_req,
  input logic       inv_valid,
  input logic       inv_ack,
  input logic [1:0] ctx_switch
);
  AST_INV_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> inv_ack);  // R6
  AST_DROP_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code[1]) |=> (op_done && op_pass && !op_go));  // R4 R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == 2'd0 && ctx_switch[op_thread]) |=> (op_done && !op_pass));  // R12
  AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (!op_ready && !op_done));  // R13
  AST_GO_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_go) |-> op_pass);  // R1
endmodule

bind ca_tag_tracker ca_tag_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_thread(op_thread), .op_ready(op_ready), .op_done(op_done),
  .op_pass(op_pass), .op_go(op_go), .fill_req(fill_req),
  .inv_valid(inv_valid), .inv_ack(inv_ack), .ctx_switch(ctx_switch)
);

// File: tb/ca_tag_tracker_tb.sv
`timescale 1ns/1ps
module ca_tag_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic        op_thread = 1'b0;
  logic [31:0] op_addr = '0;
  logic        op_ready, op_done, op_pass, op_go, rsp_thread, fill_req, inv_ack;
  logic [31:0] fill_req_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        st_valid = 1'b0;
  logic        st_thread = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  ctx_switch = 2'b00;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ca_tag_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_thread(op_thread), .op_addr(op_addr), .op_ready(op_ready),
    .op_done(op_done), .op_pass(op_pass), .op_go(op_go), .rsp_thread(rsp_thread),
    .fill_req(fill_req), .fill_req_addr(fill_req_addr), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_ack(inv_ack), .st_valid(st_valid), .st_thread(st_thread),
    .st_addr(st_addr), .ctx_switch(ctx_switch)
  );

  localparam logic [1:0] CRD = 2'd0, CWR = 2'd1, UN1 = 2'd2, UNA = 2'd3;
  localparam logic [31:0] A = 32'h1000, B = 32'h1040, E = 32'h10C0,
                          F = 32'h11C0, G = 32'h12C0, H = 32'h13C0;

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  logic p, g, m, rl;

  task automatic run_op(input logic [1:0] code, input logic t, input logic [31:0] a);
    bit sent;
    sent = 0; m = 0; rl = 0;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_thread = t; op_addr = a;
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < 20 && !op_done; i++) begin
      if (fill_req && !sent) begin
        m = 1; rl = !op_ready;
        chk("R13 fill address aligned", fill_req_addr == {a[31:6], 6'd0}, 1'b1);
        fill_valid = 1'b1; fill_addr = fill_req_addr; sent = 1;
      end
      @(negedge clk);
      fill_valid = 1'b0;
    end
    p = op_pass; g = op_go;
    chk("op_done seen", op_done, 1'b1);
    chk("rsp_thread", rsp_thread, t);
  endtask

  task automatic inval(input logic [31:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
    chk("R6 inv_ack next cycle", inv_ack, 1'b1);
  endtask

  task automatic ext_fill(input logic [31:0] a);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic drop_both();
    run_op(UNA, 1'b0, 32'h0);
    run_op(UNA, 1'b1, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset op_ready", op_ready, 1'b1);
    chk("R1 reset op_done", op_done, 1'b0);
    chk("R13 reset fill_req", fill_req, 1'b0);
    chk("R6 reset inv_ack", inv_ack, 1'b0);
    rst_n = 1'b1;

    // R1 R3 R8 R10 R13: sweep over threads, sets and byte offsets
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] ln;
        logic [5:0] oa;
        ln = 32'h1000 + 32'(s) * 64;
        oa = 6'((s * 13 + t * 29) % 64);
        run_op(CWR, 1'(t), ln + 32'(oa));
        chk("R3 untagged cwrite fails", p, 1'b0);
        chk("R3 untagged cwrite no go", g, 1'b0);
        run_op(CRD, 1'(t), ln + 32'(oa));
        chk("R1 cread passes", p, 1'b1);
        chk("R1 cread go", g, 1'b1);
        chk("R13 miss only on first touch", m, (t == 0));
        if (t == 0) chk("R13 ready low during miss", rl, 1'b1);
        run_op(CWR, 1'(t), ln + 32'(6'd63 - oa));
        chk("R10 cwrite elsewhere in line passes", p, 1'b1);
        run_op(CWR, 1'(1 - t), ln);
        chk("R8 sibling not tagged cwrite fails", p, 1'b0);
        run_op(UNA, 1'(t), 32'h0);
        chk("R5 drop-all pass", p, 1'b1);
        chk("R5 drop-all no go", g, 1'b0);
      end
    end

    // R2 R5 R6
    run_op(CRD, 1'b0, A);
    chk("R1 cread A", p, 1'b1);
    inval(A + 5);
    run_op(CRD, 1'b0, A + 8);
    chk("R2 revoked cread fails", p, 1'b0);
    chk("R2 revoked cread no go", g, 1'b0);
    chk("R2 revoked cread no fill", m, 1'b0);
    run_op(UNA, 1'b0, 32'h0);
    run_op(CRD, 1'b0, A);
    chk("R5 cread after drop-all passes", p, 1'b1);
    chk("R6 invalidated line misses", m, 1'b1);

    // R4
    run_op(UN1, 1'b0, A + 9);
    chk("R4 drop-one pass", p, 1'b1);
    chk("R4 drop-one no go", g, 1'b0);
    run_op(CWR, 1'b0, A);
    chk("R4 cwrite after drop-one fails", p, 1'b0);
    inval(A);
    run_op(CRD, 1'b0, B);
    chk("R4 invalidation of dropped line does not revoke", p, 1'b1);
    run_op(UN1, 1'b0, 32'h9000);
    chk("R4 drop-one absent line pass", p, 1'b1);
    run_op(CWR, 1'b0, B);
    chk("R4 absent drop-one left B tagged", p, 1'b1);

    // R8
    drop_both();
    run_op(CRD, 1'b0, A);
    run_op(CRD, 1'b1, B);
    inval(A);
    run_op(CRD, 1'b1, B);
    chk("R8 other thread unaffected", p, 1'b1);
    run_op(CRD, 1'b0, B);
    chk("R8 watching thread revoked", p, 1'b0);
    run_op(UNA, 1'b0, 32'h0);

    // R9
    @(negedge clk); ctx_switch = 2'b10;
    @(negedge clk); ctx_switch = 2'b00;
    run_op(CRD, 1'b1, B);
    chk("R9 context switch revokes thread 1", p, 1'b0);
    run_op(CRD, 1'b0, B);
    chk("R9 thread 0 unaffected", p, 1'b1);
    drop_both();

    // R11
    run_op(CRD, 1'b0, B);
    run_op(CRD, 1'b1, B);
    run_op(CWR, 1'b1, B + 4);
    chk("R11 cwrite passes", p, 1'b1);
    run_op(CRD, 1'b0, B);
    chk("R11 sibling cwrite revokes", p, 1'b0);
    run_op(CRD, 1'b1, B);
    chk("R11 own cwrite keeps writer", p, 1'b1);
    drop_both();
    run_op(CRD, 1'b1, B);
    @(negedge clk); st_valid = 1'b1; st_thread = 1'b0; st_addr = B + 3;
    @(negedge clk); st_valid = 1'b0;
    run_op(CRD, 1'b1, B);
    chk("R11 sibling plain store revokes", p, 1'b0);
    run_op(UNA, 1'b1, 32'h0);
    run_op(CRD, 1'b1, B);
    @(negedge clk); st_valid = 1'b1; st_thread = 1'b1; st_addr = B;
    @(negedge clk); st_valid = 1'b0;
    run_op(CRD, 1'b1, B);
    chk("R11 own plain store harmless", p, 1'b1);
    drop_both();

    // R12: event and operation in the same cycle
    run_op(CRD, 1'b0, B);
    @(negedge clk);
    op_valid = 1'b1; op_code = CWR; op_thread = 1'b0; op_addr = B;
    inv_valid = 1'b1; inv_addr = B;
    @(negedge clk);
    op_valid = 1'b0; inv_valid = 1'b0;
    chk("R12 cwrite with same-cycle invalidation done", op_done, 1'b1);
    chk("R12 cwrite with same-cycle invalidation fails", op_pass, 1'b0);
    chk("R12 no go", op_go, 1'b0);
    chk("R12 invalidation acked", inv_ack, 1'b1);
    run_op(UNA, 1'b0, 32'h0);
    @(negedge clk);
    op_valid = 1'b1; op_code = CRD; op_thread = 1'b1; op_addr = A;
    ctx_switch = 2'b10;
    @(negedge clk);
    op_valid = 1'b0; ctx_switch = 2'b00;
    chk("R12 cread with same-cycle context switch done", op_done, 1'b1);
    chk("R12 cread with same-cycle context switch fails", op_pass, 1'b0);
    chk("R12 no fill requested", fill_req, 1'b0);
    drop_both();

    // R7: set 3 holds E in way 0, pointer at way 0
    run_op(CRD, 1'b0, E);
    chk("R7 E resident", m, 1'b0);
    run_op(CRD, 1'b1, F);
    chk("R7 F fills free way", m, 1'b1);
    ext_fill(G);
    run_op(CRD, 1'b1, F);
    chk("R7 F survives first eviction", p, 1'b1);
    chk("R7 F still resident", m, 1'b0);
    run_op(CRD, 1'b0, B);
    chk("R7 eviction of E revokes thread 0", p, 1'b0);
    run_op(UNA, 1'b0, 32'h0);
    ext_fill(H);
    run_op(CRD, 1'b0, B);
    chk("R7 thread 0 clean after drop-all", p, 1'b1);
    run_op(CRD, 1'b1, B);
    chk("R7 round-robin evicts F and revokes thread 1", p, 1'b0);
    run_op(UNA, 1'b1, 32'h0);
    run_op(CRD, 1'b1, F);
    chk("R7 F was evicted", m, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule